// File: doc/BRIEF.md
# Eight-Line Priority Interrupt Controller

This block collects up to eight interrupt request lines, holds pending requests, tracks which interrupts are being serviced, and signals the processor when a request should be taken. It follows the register model of the classic PC interrupt controller. There is a request register, an in-service register and a mask register. A short initialization sequence loads the vector base. The processor then answers the interrupt output with two acknowledge pulses and reads the vector byte on the second one.

Software talks to the block through a two-address port. Writes to the even address carry the first initialization word and the run-time commands, and reads there return the request or in-service register. Writes to the odd address carry the remaining initialization words and, once running, the mask. A single cascade request input is OR-ed onto line 2. This stands in for a second controller hanging off that line.

Two service disciplines can be chosen. In automatic end-of-interrupt mode the in-service bit is dropped by the block itself at the end of the acknowledge sequence. In special mask mode, in-service bits stop holding back lower-priority requests, so only the mask decides.

Top module: `prio_intc`

## Requirements
- R1: After reset, int_out and vec_valid are 0, vec_out is 0x00, and reads at both addresses return 0x00.
- R2: An even-address write with bit 4 set starts initialization. It clears the request, in-service and mask registers, special mask mode, the automatic end-of-interrupt option and the read select (back to the request register). Bit 0 set means a fourth word follows, and bit 1 clear means a cascade word follows. The next odd writes are, in order: the vector base (bits 7:3), the cascade word if expected (contents ignored), and the fourth word if expected. Request edges are ignored until the sequence completes.
- R3: Once running, a rising edge on a request line sets its request bit. The bit clears if the line is low before it is acknowledged. A line held high after its acknowledge does not set the bit again.
- R4: Odd-address writes while running load the mask register, whose bit n masks line n. Odd reads return the mask. A masked request stays latched but does not raise int_out.
- R5: Priority is fixed, line 0 highest. In normal mode a request is eligible only if it is unmasked and no in-service bit of equal or higher priority is set. int_out is high exactly when an eligible request exists.
- R6: The rising edge of the first acknowledge pulse moves the highest-priority eligible request from the request register to the in-service register. From the cycle after the second pulse rises until it falls, vec_valid is 1 and vec_out is {vector base, line number}.
- R7: An even-address write with bits 4:3 = 00 and bits 7:5 = 001 (value 0x20) clears the highest-priority set in-service bit.
- R8: With bit 1 of the fourth initialization word set, the highest-priority set in-service bit is cleared when the second acknowledge pulse falls.
- R9: An even-address write with bits 4:3 = 01 is a mode command. Bit 6 = 1 with bit 5 = 1 turns special mask mode on, and bit 6 = 1 with bit 5 = 0 turns it off. With bit 6 = 0 the mode is unchanged. In special mask mode every unmasked pending request is eligible regardless of in-service bits.
- R10: In the same mode command, bit 1 = 1 selects the even-address read source from bit 0 (1 = in-service register, 0 = request register). Bit 1 = 0 leaves the selection unchanged.
- R11: The cascade request input acts as request line 2, and mask bit 2 blocks it.
- R12: An acknowledge sequence with no eligible request returns line number 7 in the vector and changes no in-service bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | One-cycle register write strobe |
| addr | input | 1 | Register address: 0 command/status, 1 mask/data |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the addressed register |
| irq_in | input | 8 | Request lines 0 to 7 |
| cascade_req | input | 1 | Request from a downstream controller, merged onto line 2 |
| inta | input | 1 | Acknowledge pulse, high while active |
| int_out | output | 1 | Interrupt request to the processor |
| vec_out | output | 8 | Vector byte during the second acknowledge pulse, else 0 |
| vec_valid | output | 1 | High while vec_out carries the vector |

## Verification
The bench walks nested interrupts where a higher line pre-empts one already in service. A design that ignored in-service blocking would raise int_out for the lower line, and one that compared priority the wrong way round would block the higher line. It checks that a level held high after acknowledge does not come back, and that a line falling before acknowledge is withdrawn; level-sensitive latching breaks the first, sticky latching the second. It exercises the mode command with its enable bit clear, the optional cascade word in the initialization order, automatic clearing on the second falling pulse, a masked cascade input, and an acknowledge with nothing pending. Getting these wrong would leave special mask mode toggled by mistake, load the vector base from the wrong word, leave an in-service bit stuck, or make up a line number.

// File: rtl/prio_intc.sv
module prio_intc (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic [7:0] irq_in,
  input  logic       cascade_req,
  input  logic       inta,
  output logic       int_out,
  output logic [7:0] vec_out,
  output logic       vec_valid
);

  typedef enum logic [2:0] {S_OFF, S_W2, S_W3, S_W4, S_RUN} init_t;

  init_t      st;
  logic [7:0] irr, isr, imr;
  logic [7:0] lines, lines_d;
  logic [4:0] vbase;
  logic       need4, single, aeoi, smm, rsel;
  logic [1:0] ph;
  logic       inta_d;
  logic [2:0] sel;
  logic       ready;

  logic [7:0] pend, elig, isr_top, take_bit;
  logic [2:0] win;
  logic       any, blocked;

  assign ready = (st == S_RUN);
  assign lines = irq_in | {5'b0, cascade_req, 2'b0};

  wire wr_cmd   = wr_en && !addr;
  wire wr_dat   = wr_en && addr;
  wire icw1     = wr_cmd && wdata[4];
  wire ocw2     = wr_cmd && ready && (wdata[4:3] == 2'b00);
  wire ocw3     = wr_cmd && ready && (wdata[4:3] == 2'b01);
  wire eoi_cmd  = ocw2 && (wdata[7:5] == 3'b001);
  wire a_rise   = inta && !inta_d;
  wire a_fall   = !inta && inta_d;
  wire take     = a_rise && (ph == 2'd0) && ready;
  wire auto_eoi = a_fall && (ph == 2'd3) && aeoi;

  always_comb begin
    pend    = irr & ~imr;
    elig    = '0;
    blocked = 1'b0;
    for (int i = 0; i < 8; i++) begin
      if (isr[i] && !smm) blocked = 1'b1;
      if (pend[i] && !blocked) elig[i] = 1'b1;
    end
    win = 3'd7;
    any = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      if (elig[i]) begin
        win = 3'(i);
        any = 1'b1;
      end
    end
  end

  assign isr_top  = isr & (~isr + 8'd1);
  assign take_bit = (take && any) ? (8'd1 << win) : 8'd0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lines_d <= '0;
      inta_d  <= 1'b0;
      irr     <= '0;
      isr     <= '0;
      ph      <= 2'd0;
      sel     <= 3'd7;
    end else begin
      lines_d <= lines;
      inta_d  <= inta;
      if (icw1 || !ready) irr <= '0;
      else irr <= ((irr | (lines & ~lines_d)) & lines) & ~take_bit;
      if (icw1) isr <= '0;
      else isr <= (isr | take_bit) & ~((eoi_cmd || auto_eoi) ? isr_top : 8'd0);
      if (take) sel <= any ? win : 3'd7;
      case (ph)
        2'd0:    if (a_rise) ph <= 2'd1;
        2'd1:    if (a_fall) ph <= 2'd2;
        2'd2:    if (a_rise) ph <= 2'd3;
        default: if (a_fall) ph <= 2'd0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_OFF;
      imr    <= '0;
      vbase  <= '0;
      need4  <= 1'b0;
      single <= 1'b1;
      aeoi   <= 1'b0;
      smm    <= 1'b0;
      rsel   <= 1'b0;
    end else if (icw1) begin
      st     <= S_W2;
      need4  <= wdata[0];
      single <= wdata[1];
      imr    <= '0;
      aeoi   <= 1'b0;
      smm    <= 1'b0;
      rsel   <= 1'b0;
    end else begin
      if (wr_dat) begin
        case (st)
          S_W2: begin
            vbase <= wdata[7:3];
            st    <= !single ? S_W3 : (need4 ? S_W4 : S_RUN);
          end
          S_W3: st <= need4 ? S_W4 : S_RUN;
          S_W4: begin
            aeoi <= wdata[1];
            st   <= S_RUN;
          end
          S_RUN:   imr <= wdata;
          default: ;
        endcase
      end
      if (ocw3) begin
        if (wdata[6]) smm  <= wdata[5];
        if (wdata[1]) rsel <= wdata[0];
      end
    end
  end

  assign int_out   = ready && any;
  assign vec_valid = (ph == 2'd3);
  assign vec_out   = vec_valid ? {vbase, sel} : 8'h00;
  assign rdata     = addr ? imr : (rsel ? isr : irr);

endmodule

// File: rtl/prio_intc_chk.sv
module prio_intc_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic       addr,
  input logic [7:0] wdata,
  input logic       inta,
  input logic       int_out,
  input logic       vec_valid,
  input logic [7:0] irr,
  input logic [7:0] isr,
  input logic [7:0] imr,
  input logic       ready,
  input logic       aeoi
);

  p_init_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !addr && wdata[4]) |=> (isr == 8'h00 && imr == 8'h00 && !int_out));

  p_mask_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr && ready) |=> (imr == $past(wdata)));

  p_int_unmasked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    int_out |-> (|(irr & ~imr)));

  p_vec_after_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vec_valid) |-> $past(inta));

  p_auto_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && !inta && aeoi && isr != 8'h00)
      |=> ($countones(isr) + 1 == $countones($past(isr))));

endmodule

bind prio_intc prio_intc_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .inta(inta), .int_out(int_out), .vec_valid(vec_valid),
  .irr(irr), .isr(isr), .imr(imr), .ready(ready), .aeoi(aeoi)
);

// File: tb/tb_prio_intc.sv
module tb_prio_intc;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic       addr = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [7:0] irq_in = '0;
  logic       cascade_req = 1'b0;
  logic       inta = 1'b0;
  logic       int_out;
  logic [7:0] vec_out;
  logic       vec_valid;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  logic [7:0] got_vec;

  always #2.5 clk = ~clk;

  prio_intc dut (.*);

  // op: 0 even write, 1 odd write, 2 set request lines, 3 acknowledge sequence
  // fields: {op[1:0], data[7:0], expected int_out, expected value}
  localparam int NV = 22;
  localparam logic [18:0] TBL [NV] = '{
    {2'd0, 8'h13, 1'b0, 8'h00},  // R2 first init word
    {2'd1, 8'h40, 1'b0, 8'h00},  // R2 vector base
    {2'd1, 8'h00, 1'b0, 8'h00},  // R2 fourth word, no auto clear
    {2'd2, 8'h28, 1'b1, 8'h28},  // R3 lines 3 and 5 rise
    {2'd3, 8'h00, 1'b0, 8'h43},  // R6 line 3 taken, R5 line 5 blocked
    {2'd0, 8'h0B, 1'b0, 8'h08},  // R10 read in-service
    {2'd2, 8'h29, 1'b1, 8'h08},  // R5 line 0 pre-empts
    {2'd3, 8'h00, 1'b0, 8'h40},  // R6 nested take
    {2'd0, 8'h20, 1'b0, 8'h08},  // R7 clears line 0
    {2'd0, 8'h20, 1'b1, 8'h00},  // R7 clears line 3, line 5 eligible
    {2'd1, 8'h20, 1'b0, 8'h20},  // R4 mask line 5
    {2'd1, 8'h00, 1'b1, 8'h00},  // R4 unmask
    {2'd0, 8'h68, 1'b1, 8'h00},  // R9 special mask on
    {2'd3, 8'h00, 1'b0, 8'h45},  // R6 line 5 taken
    {2'd2, 8'h09, 1'b0, 8'h20},  // R3 line 5 low, nothing new
    {2'd2, 8'h89, 1'b1, 8'h20},  // R9 line 7 passes in-service line 5
    {2'd3, 8'h00, 1'b0, 8'h47},  // R9 line 7 taken
    {2'd0, 8'h48, 1'b0, 8'hA0},  // R9 special mask off
    {2'd0, 8'h20, 1'b0, 8'h80},  // R7
    {2'd0, 8'h20, 1'b0, 8'h00},  // R7
    {2'd0, 8'h0A, 1'b0, 8'h00},  // R10 read requests
    {2'd2, 8'h00, 1'b0, 8'h00}   // R3 all lines low
  };

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      n_chk = n_chk + 1;
      n_bad = n_bad + 1;
      $display("FAIL watchdog: act=%0d cycles exp=completion", cyc);
      finish_run();
    end
  end

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_chk = n_chk + 1;
    if (act !== exp) begin
      n_bad = n_bad + 1;
      $display("FAIL %s: act=%02h exp=%02h", req, act, exp);
    end
  endtask

  task automatic wr(logic a, logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic lines_to(logic [7:0] v);
    @(negedge clk);
    irq_in = v;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic ack();
    @(negedge clk); inta = 1'b1;
    @(negedge clk); @(negedge clk); inta = 1'b0;
    @(negedge clk); @(negedge clk); inta = 1'b1;
    @(negedge clk); @(negedge clk);
    got_vec = vec_valid ? vec_out : 8'hEE;
    inta = 1'b0;
    @(negedge clk); @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 int_out", {7'b0, int_out}, 8'h00);
    check("R1 vec_valid", {7'b0, vec_valid}, 8'h00);
    check("R1 vec_out", vec_out, 8'h00);
    addr = 1'b0; #0.1;
    check("R1 even read", rdata, 8'h00);
    addr = 1'b1; #0.1;
    check("R1 odd read", rdata, 8'h00);
    rst_n = 1'b1;

    lines_to(8'h01);
    addr = 1'b0; #0.1;
    check("R2 no int before init", {7'b0, int_out}, 8'h00);
    check("R2 no request before init", rdata, 8'h00);
    lines_to(8'h00);

    for (int k = 0; k < NV; k++) begin
      logic [1:0] op;
      logic [7:0] d, ev, val;
      logic       ei;
      {op, d, ei, ev} = TBL[k];
      case (op)
        2'd0: wr(1'b0, d);
        2'd1: wr(1'b1, d);
        2'd2: lines_to(d);
        default: ack();
      endcase
      addr = (op == 2'd1);
      #0.1;
      val = (op == 2'd3) ? got_vec : rdata;
      check($sformatf("R5 table step %0d int_out", k), {7'b0, int_out}, {7'b0, ei});
      check($sformatf("R6 table step %0d value", k), val, ev);
    end

    // R9: mode command with enable clear leaves normal mode
    wr(1'b0, 8'h13); wr(1'b1, 8'h40); wr(1'b1, 8'h00);
    lines_to(8'h02);
    ack();
    check("R6 line 1 vector", got_vec, 8'h41);
    lines_to(8'h12);
    check("R5 line 4 blocked by line 1", {7'b0, int_out}, 8'h00);
    wr(1'b0, 8'h28);
    check("R9 enable clear keeps normal mode", {7'b0, int_out}, 8'h00);
    wr(1'b0, 8'h68);
    check("R9 special mask lets line 4 through", {7'b0, int_out}, 8'h01);
    wr(1'b0, 8'h48);
    check("R9 special mask off again", {7'b0, int_out}, 8'h00);
    lines_to(8'h00);

    // R2 with cascade word, R8 automatic clear, R11 cascade input
    wr(1'b0, 8'h11); wr(1'b1, 8'h80); wr(1'b1, 8'h04); wr(1'b1, 8'h02);
    addr = 1'b1; #0.1;
    check("R2 mask clear after init", rdata, 8'h00);
    wr(1'b0, 8'h0B);
    @(negedge clk); cascade_req = 1'b1; @(negedge clk); @(negedge clk);
    check("R11 cascade raises int", {7'b0, int_out}, 8'h01);
    ack();
    check("R11 cascade vector on line 2", got_vec, 8'h82);
    addr = 1'b0; #0.1;
    check("R8 in-service cleared at end of ack", rdata, 8'h00);
    check("R8 no int after ack", {7'b0, int_out}, 8'h00);

    wr(1'b1, 8'h04);
    @(negedge clk); cascade_req = 1'b0; @(negedge clk); cascade_req = 1'b1;
    @(negedge clk); @(negedge clk);
    wr(1'b0, 8'h0A);
    addr = 1'b0; #0.1;
    check("R4 masked request still latched", rdata, 8'h04);
    check("R11 mask bit 2 blocks cascade", {7'b0, int_out}, 8'h00);
    wr(1'b1, 8'h00);
    check("R4 unmask releases request", {7'b0, int_out}, 8'h01);
    @(negedge clk); cascade_req = 1'b0; @(negedge clk); @(negedge clk);
    addr = 1'b0; #0.1;
    check("R3 low line withdraws request", rdata, 8'h00);
    check("R3 int drops with request", {7'b0, int_out}, 8'h00);

    // R12 acknowledge with nothing pending
    wr(1'b0, 8'h0B);
    ack();
    check("R12 empty ack gives line 7", got_vec, 8'h87);
    addr = 1'b0; #0.1;
    check("R12 in-service unchanged", rdata, 8'h00);

    finish_run();
  end

endmodule